// File: doc/BRIEF.md
# Polynomial-Hash MAC Address Lookup Engine

This engine decides whether a 48-bit station address is known to a bridge port and, if it is, returns where its record lives and the 16 bits of data kept with it. The address is first scrambled by a programmable multiply over GF(2), reduced by a fixed degree-48 polynomial. Because that mapping is a bijection, the low hash bits can pick a bucket and the high 32 bits alone identify the address inside it.

A bucket word read from external synchronous SRAM says how many known addresses share the bucket and where their records start. The engine then bisects that sorted record array. A lookup costs one bucket read plus at most three record reads. A miss in a bucket that is already full is flagged so that the caller can try its overflow store.

Top module: `hash_lookup_engine`

## Requirements
- R1: After reset `res_valid` and `mem_re` are low and `req_ready` is high.
- R2: The hash is M(X)·A(X) mod (X^48 + X^36 + X^25 + X^10 + 1) over GF(2). Here M is the multiplier most recently loaded with `cfg_we` and A is `req_mac`, with bit i the coefficient of X^i. The first SRAM read of a lookup goes to the address given by hash bits [15:0], zero-extended.
- R3: With the default one bit per cycle, the first read strobe is seen 49 clock edges after the edge that accepts the request. More generally this is 48/UNROLL + 1 edges.
- R4: The bucket word is SRAM data bits [31:0]. Bits [2:0] hold the count and bits [31:3] hold the record pointer. A count of 0 ends the lookup as a miss without overflow, after exactly one read.
- R5: Records sit at pointer + i for i = 0 .. count-1, sorted ascending by key. A record word carries its key (upper 32 hash bits) in [47:16] and its data in [15:0]. A lookup hits only when a record key equals hash bits [47:16]. On a hit, `res_ptr` is that record's address and `res_data` is its data.
- R6: The record search keeps a half-open range [lo, end) that starts as [0, count). Each step reads index floor((lo+end-1)/2). A smaller probe sets end to that index, and a larger probe sets lo to that index plus one. The search misses when the range becomes empty. No lookup makes more than four reads.
- R7: `res_ovf` is high exactly when a lookup misses in a bucket whose count is 7. It is never high together with `res_hit`.
- R8: Each accepted request yields one single-cycle `res_valid` pulse. Its `res_reads` equals the number of `mem_re` cycles the lookup used.
- R9: `req_ready` is low from the cycle after acceptance until the result pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the hash multiplier |
| cfg_mult | input | 48 | Multiplier value (nonzero) |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Engine idle, request accepted |
| req_mac | input | 48 | Address to look up |
| mem_re | output | 1 | SRAM read strobe |
| mem_addr | output | 29 | SRAM word address |
| mem_rdata | input | 48 | SRAM data, valid the cycle after the strobe |
| res_valid | output | 1 | Result pulse |
| res_hit | output | 1 | Address found |
| res_ovf | output | 1 | Missed in a full bucket |
| res_ptr | output | 29 | Address of the matching record |
| res_data | output | 16 | Data stored with the record |
| res_reads | output | 3 | SRAM reads spent on this lookup |

## Verification
The properties assume that the table in SRAM is well formed: each nonempty bucket's records are sorted and unique, and the multiplier is never zero. They also assume that requests only arrive while `req_ready` is high and that the multiplier is not changed during a lookup. The stimulus keeps within these limits in three ways. It builds every bucket from sorted key lists in its own sparse memory model. It loads only nonzero multipliers, and only between lookups. It issues each request only from the idle state and waits for its result before the next. Buckets of every count from 0 to 7 are probed at each stored key and in each gap around them. Random multipliers exercise the reduction path.

// File: rtl/lk_pkg.sv
package lk_pkg;
  localparam int HASH_W = 48;
  localparam int KEY_W  = 32;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 3;
  localparam int BKT_W  = 32;
  localparam int PTR_W  = BKT_W - CNT_W;
  localparam int POS_W  = CNT_W + 1;
  localparam int RD_W   = 3;
  // low-order terms of the reduction polynomial (X^36 + X^25 + X^10 + 1)
  localparam logic [HASH_W-1:0] G_TAPS = 48'h0010_0200_0401;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HASH, ST_BKT_REQ, ST_BKT_DAT, ST_REC_REQ, ST_REC_DAT
  } lk_state_e;
endpackage

// File: rtl/lk_gf_hasher.sv
module lk_gf_hasher #(
  parameter int W = 48,
  parameter int UNROLL = 1,
  parameter logic [W-1:0] TAPS = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] addr,
  input  logic [W-1:0] mult,
  output logic         done,
  output logic [W-1:0] hash
);
  localparam int STEPS = W / UNROLL;
  localparam int CW = $clog2(STEPS + 1);

  logic [W-1:0] acc, a_sh;
  logic [CW-1:0] cnt;
  logic run;
  logic [W-1:0] chain [UNROLL+1];

  assign chain[0] = acc;
  // Horner form, MSB of the address first: acc = acc*X mod G + a_i*M
  for (genvar u = 0; u < UNROLL; u++) begin : g_step
    logic [W-1:0] shifted;
    assign shifted = {chain[u][W-2:0], 1'b0} ^ (chain[u][W-1] ? TAPS : '0);
    assign chain[u+1] = shifted ^ (a_sh[W-1-u] ? mult : '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      acc  <= '0;
      a_sh <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        acc  <= '0;
        a_sh <= addr;
        cnt  <= '0;
        run  <= 1'b1;
      end else if (run) begin
        acc  <= chain[UNROLL];
        a_sh <= a_sh << UNROLL;
        cnt  <= cnt + 1'b1;
        if (cnt == CW'(STEPS - 1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign hash = acc;
endmodule

// File: rtl/lk_bisect.sv
module lk_bisect #(
  parameter int KW = 32,
  parameter int PW = 4
) (
  input  logic [PW-1:0] lo,
  input  logic [PW-1:0] hi_x,
  input  logic [PW-1:0] mid,
  input  logic [KW-1:0] probe,
  input  logic [KW-1:0] rec_key,
  output logic          match,
  output logic          empty,
  output logic [PW-1:0] nlo,
  output logic [PW-1:0] nhi_x,
  output logic [PW-1:0] nmid
);
  always_comb begin
    match = (probe == rec_key);
    if (probe < rec_key) begin
      nlo   = lo;
      nhi_x = mid;
    end else begin
      nlo   = mid + 1'b1;
      nhi_x = hi_x;
    end
    empty = match ? 1'b0 : (nlo >= nhi_x);
    nmid  = (nlo + nhi_x - 1'b1) >> 1;
  end
endmodule

// File: rtl/hash_lookup_engine.sv
module hash_lookup_engine
  import lk_pkg::*;
#(
  parameter int UNROLL = 1,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [HASH_W-1:0] cfg_mult,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [HASH_W-1:0] req_mac,
  output logic              mem_re,
  output logic [PTR_W-1:0]  mem_addr,
  input  logic [HASH_W-1:0] mem_rdata,
  output logic              res_valid,
  output logic              res_hit,
  output logic              res_ovf,
  output logic [PTR_W-1:0]  res_ptr,
  output logic [DATA_W-1:0] res_data,
  output logic [RD_W-1:0]   res_reads
);
  localparam logic [CNT_W-1:0] FULL_CNT = '1;

  lk_state_e state;
  logic [HASH_W-1:0] mult_q, hash;
  logic hash_done, accept;
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] ptr_q;
  logic [POS_W-1:0] lo_q, hi_q, mid_q;
  logic [RD_W-1:0]  reads_q;
  logic match, empty;
  logic [POS_W-1:0] nlo, nhi, nmid;
  logic [CNT_W-1:0] b_cnt;
  logic [PTR_W-1:0] b_ptr;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign b_cnt     = mem_rdata[CNT_W-1:0];
  assign b_ptr     = mem_rdata[BKT_W-1:CNT_W];

  lk_gf_hasher #(.W(HASH_W), .UNROLL(UNROLL), .TAPS(G_TAPS)) u_hash (
    .clk(clk), .rst(rst), .start(accept), .addr(req_mac),
    .mult(mult_q), .done(hash_done), .hash(hash)
  );

  lk_bisect #(.KW(KEY_W), .PW(POS_W)) u_bis (
    .lo(lo_q), .hi_x(hi_q), .mid(mid_q),
    .probe(hash[HASH_W-1:HASH_W-KEY_W]), .rec_key(mem_rdata[HASH_W-1:DATA_W]),
    .match(match), .empty(empty), .nlo(nlo), .nhi_x(nhi), .nmid(nmid)
  );

  always_ff @(posedge clk) begin
    if (rst) mult_q <= HASH_W'(1);
    else if (cfg_we) mult_q <= cfg_mult;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_re    <= 1'b0;
      mem_addr  <= '0;
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_ovf   <= 1'b0;
      res_ptr   <= '0;
      res_data  <= '0;
      res_reads <= '0;
      cnt_q     <= '0;
      ptr_q     <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      mid_q     <= '0;
      reads_q   <= '0;
    end else begin
      mem_re    <= 1'b0;
      res_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          reads_q <= '0;
          state   <= ST_HASH;
        end
        ST_HASH: if (hash_done) begin
          mem_re   <= 1'b1;
          mem_addr <= PTR_W'(hash[IDX_W-1:0]);
          reads_q  <= reads_q + 1'b1;
          state    <= ST_BKT_REQ;
        end
        ST_BKT_REQ: state <= ST_BKT_DAT;
        ST_BKT_DAT: begin
          cnt_q <= b_cnt;
          ptr_q <= b_ptr;
          if (b_cnt == '0) begin
            res_valid <= 1'b1;
            res_hit   <= 1'b0;
            res_ovf   <= 1'b0;
            res_ptr   <= '0;
            res_data  <= '0;
            res_reads <= reads_q;
            state     <= ST_IDLE;
          end else begin
            lo_q     <= '0;
            hi_q     <= POS_W'(b_cnt);
            mid_q    <= POS_W'(b_cnt - 1'b1) >> 1;
            mem_re   <= 1'b1;
            mem_addr <= b_ptr + PTR_W'((b_cnt - 1'b1) >> 1);
            reads_q  <= reads_q + 1'b1;
            state    <= ST_REC_REQ;
          end
        end
        ST_REC_REQ: state <= ST_REC_DAT;
        ST_REC_DAT: begin
          if (match || empty) begin
            res_valid <= 1'b1;
            res_hit   <= match;
            res_ovf   <= empty && (cnt_q == FULL_CNT);
            res_ptr   <= match ? ptr_q + PTR_W'(mid_q) : '0;
            res_data  <= match ? mem_rdata[DATA_W-1:0] : '0;
            res_reads <= reads_q;
            state     <= ST_IDLE;
          end else begin
            lo_q     <= nlo;
            hi_q     <= nhi;
            mid_q    <= nmid;
            mem_re   <= 1'b1;
            mem_addr <= ptr_q + PTR_W'(nmid);
            reads_q  <= reads_q + 1'b1;
            state    <= ST_REC_REQ;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lk_checker.sv
module lk_checker (
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_ready,
  input logic       mem_re,
  input logic       res_valid,
  input logic       res_hit,
  input logic       res_ovf,
  input logic [2:0] res_reads
);
  logic [3:0] rd_q;

  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else if (req_valid && req_ready) rd_q <= '0;
    else if (mem_re) rd_q <= rd_q + 1'b1;
  end

  AST_READ_BOUND: assert property (@(posedge clk) disable iff (rst)
    rd_q <= 4'd4); // R6
  AST_HIT_NOT_OVF: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !(res_hit && res_ovf)); // R7
  AST_RES_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid); // R8
  AST_READS_MATCH: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (4'(res_reads) == rd_q)); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready); // R9
  AST_EMPTY_MISS: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_reads == 3'd1) |-> (!res_hit && !res_ovf)); // R4
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (rst)
    mem_re |=> !mem_re); // R6
endmodule

bind hash_lookup_engine lk_checker u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .mem_re(mem_re), .res_valid(res_valid), .res_hit(res_hit),
  .res_ovf(res_ovf), .res_reads(res_reads)
);

// File: tb/sim_hash_lookup_engine.sv
module sim_hash_lookup_engine;
  localparam int STEPS = 48;
  localparam logic [47:0] TAPS = 48'h0010_0200_0401;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [47:0] cfg_mult = '0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [47:0] req_mac = '0;
  logic mem_re;
  logic [28:0] mem_addr;
  logic [47:0] mem_rdata = '0;
  logic res_valid, res_hit, res_ovf;
  logic [28:0] res_ptr;
  logic [15:0] res_data;
  logic [2:0] res_reads;

  int total = 0;
  int bad = 0;
  int rd_cnt = 0;
  logic [28:0] first_addr;
  logic [47:0] mem [logic [28:0]];

  always #4 clk = ~clk;

  hash_lookup_engine u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_mult(cfg_mult),
    .req_valid(req_valid), .req_ready(req_ready), .req_mac(req_mac),
    .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_hit(res_hit), .res_ovf(res_ovf),
    .res_ptr(res_ptr), .res_data(res_data), .res_reads(res_reads)
  );

  always @(posedge clk) begin
    if (mem_re) begin
      if (rd_cnt == 0) first_addr = mem_addr;
      rd_cnt = rd_cnt + 1;
      mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 48'h0;
    end
  end

  function automatic logic [47:0] gf_ref(logic [47:0] m, logic [47:0] a);
    logic [94:0] p;
    logic [94:0] g;
    p = '0;
    g = {46'b0, 1'b1, TAPS};
    for (int i = 0; i < 48; i++) if (a[i]) p = p ^ ({47'b0, m} << i);
    for (int k = 94; k >= 48; k--) if (p[k]) p = p ^ (g << (k - 48));
    return p[47:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic lookup(input logic [47:0] mult, input logic [47:0] mac, input bit e_hit,
                        input bit e_ovf, input logic [28:0] e_ptr, input logic [15:0] e_data,
                        input int e_reads);
    logic [47:0] h;
    int k;
    int w;
    h = gf_ref(mult, mac);
    @(negedge clk);
    rd_cnt = 0;
    req_valid = 1'b1;
    req_mac = mac;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9 busy after accept", req_ready, 0);
    k = 0;
    while (!mem_re && k < 200) begin
      @(posedge clk);
      k++;
      @(negedge clk);
    end
    chk(k == STEPS + 1, "R3 first read latency", k, STEPS + 1);
    w = 0;
    while (!res_valid && w < 200) begin
      @(negedge clk);
      w++;
    end
    chk(res_valid, "R8 result pulse", res_valid, 1);
    chk(first_addr == {13'b0, h[15:0]}, "R2 bucket address", first_addr, h[15:0]);
    chk(res_hit == e_hit, "R5 hit flag", res_hit, e_hit);
    chk(res_ovf == e_ovf, "R7 overflow flag", res_ovf, e_ovf);
    if (e_hit) begin
      chk(res_ptr == e_ptr, "R5 record pointer", res_ptr, e_ptr);
      chk(res_data == e_data, "R5 record data", res_data, e_data);
    end
    chk(res_reads == 3'(e_reads), "R6 read count", res_reads, e_reads);
    chk(rd_cnt == e_reads, "R8 strobes seen", rd_cnt, e_reads);
    @(negedge clk);
    chk(!res_valid, "R8 single pulse", res_valid, 0);
  endtask

  task automatic load_mult(input logic [47:0] m);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_mult = m;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // probe a sorted array of n keys by bisection; returns reads and hit index
  task automatic expect_search(input int n, input logic [31:0] keys [7], input logic [31:0] probe,
                               output int reads, output int idx);
    int lo;
    int hx;
    int mid;
    lo = 0;
    hx = n;
    reads = 1;
    idx = -1;
    while (lo < hx && idx < 0) begin
      mid = (lo + hx - 1) / 2;
      reads++;
      if (keys[mid] == probe) idx = mid;
      else if (probe < keys[mid]) hx = mid;
      else lo = mid + 1;
    end
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] keys [7];
    logic [47:0] m;
    logic [47:0] a;
    logic [47:0] h;
    logic [28:0] p;
    int reads;
    int idx;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b0, "R1 res_valid at reset", res_valid, 0);
    chk(mem_re == 1'b0, "R1 mem_re at reset", mem_re, 0);
    chk(req_ready == 1'b1, "R1 ready at reset", req_ready, 1);

    // multiplier 1: hash equals the address, buckets of every count 0..7
    load_mult(48'h1);
    for (int n = 0; n < 8; n++) begin
      logic [15:0] b;
      b = 16'h0010 + 16'(n);
      p = 29'h10_0000 + 29'(n * 16);
      mem[{13'b0, b}] = {16'b0, p, 3'(n)};
      for (int j = 0; j < 7; j++) keys[j] = 32'h1000_0000 + 32'(n << 8) + 32'(4 * (j + 1));
      for (int j = 0; j < n; j++) mem[p + 29'(j)] = {keys[j], 16'hA000 + 16'(n * 16 + j)};
      for (int j = 0; j < n; j++) begin
        expect_search(n, keys, keys[j], reads, idx);
        lookup(48'h1, {keys[j], b}, 1'b1, 1'b0, p + 29'(j), 16'hA000 + 16'(n * 16 + j), reads);
      end
      for (int j = 0; j <= n; j++) begin
        logic [31:0] gap;
        gap = 32'h1000_0000 + 32'(n << 8) + 32'(4 * j + 2);
        expect_search(n, keys, gap, reads, idx);
        // R4 empty bucket, R7 full bucket miss
        lookup(48'h1, {gap, b}, 1'b0, (n == 7), 29'h0, 16'h0, reads);
      end
    end

    // R11-style reconfiguration: random multipliers, single-record buckets (R2)
    for (int r = 0; r < 3; r++) begin
      mem.delete();
      m = (r == 0) ? 48'h2 : {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
      if (m == 48'h0) m = 48'h3;
      load_mult(m);
      for (int i = 0; i < 12; i++) begin
        if (i == 0) a = 48'h8000_0000_0000;
        else if (i == 1) a = 48'hFFFF_FFFF_FFFF;
        else a = {$urandom(), $urandom()} & 48'hFFFF_FFFF_FFFF;
        h = gf_ref(m, a);
        if (!mem.exists({13'b0, h[15:0]})) begin
          p = 29'h20_0000 + 29'(r * 64 + i);
          mem[{13'b0, h[15:0]}] = {16'b0, p, 3'd1};
          mem[p] = {h[47:16], 16'h5000 + 16'(i)};
          lookup(m, a, 1'b1, 1'b0, p, 16'h5000 + 16'(i), 2);
          // R5 one-bit change of the stored key: miss after two reads
          mem[p] = {h[47:16] ^ 32'h1, 16'h5000 + 16'(i)};
          lookup(m, a, 1'b0, 1'b0, p, 16'h0, 2);
        end
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule